// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

This block is a timer peripheral that produces eight pulse-width-modulated outputs from a single 16-bit up-counter. Software configures it through 32-bit registers reached over a request/response bus that uses valid/ready on both sides. A control register selects the counter's tick source and a power-of-two prescaler. The tick source is off, the system clock (every cycle), or one of two tick strobes, `tick_fix` and `tick_ext`, which share the system clock domain. The counter runs from a programmable start value up to a common modulus and then reloads. That modulus sets one period for every channel.

Each channel compares the shared count with its own compare value to form an edge-aligned waveform. A per-channel mask bit can replace that waveform with a per-channel init bit, and a per-channel polarity bit inverts the result. The modulus and compare values are double-buffered: software writes go to a buffer, and the counter copies the buffer into the active copy only on a reload. This keeps a period from being cut short while it is running.

Bus rules:
- A request is accepted on a rising edge where `req_valid` and `req_ready` are both high.
- Every accepted request, read or write, returns exactly one response one cycle later. For a write, or for a read of an unmapped offset, `rsp_rdata` is zero.
- The response stays valid with stable data until `rsp_ready` is sampled high.
- While a response is pending, `req_ready` is low, so no second request is accepted.

Top module: `pwm8_timer`

## Requirements
- R1: Register offsets are fixed as follows.

  | Offset | Contents |
  |---|---|
  | 0x00 | control: bits[2:0] prescaler exponent PS, bits[4:3] tick source |
  | 0x04 | counter |
  | 0x08 | modulus |
  | 0x0C+8n | control of channel n (n = 0 to 7) |
  | 0x10+8n | compare value of channel n |
  | 0x4C | counter start value |
  | 0x5C | init bits |
  | 0x60 | mask |
  | 0x70 | polarity |

  A channel control register reads back only bits [5:2]. After reset the mask reads 0xFF and every other register reads 0. Reads of any other offset, including any offset not a multiple of 4, return 0, and writes to those offsets change nothing.
- R2: Each accepted request gives one response on the next cycle. The response holds with stable data while `rsp_ready` is low, and `req_ready` is low while a response is pending.
- R3: The tick source codes are 0 = stopped, 1 = every cycle, 2 = `tick_fix`, 3 = `tick_ext`. The counter advances once every 2^PS source ticks, and with code 0 it holds its value.
- R4: The counter steps by one from the start value up to the active modulus. On the next advance it reloads the start value, so a period lasts modulus − start + 1 counts.
- R5: A read of the counter returns the live count. Writing any value to the counter reloads it with the start value and restarts the prescaler.
- R6: A channel whose control has bit 5 and bit 3 set outputs 1 while count < compare and 0 otherwise. Any other control setting gives 0 before mask and polarity are applied.
- R7: A compare value of 0 gives a constant 0, and a compare value above the modulus gives a constant 1 over the whole period.
- R8: New modulus and compare values take effect only at the next reload, whether that reload comes from a wrap or from a counter write.
- R9: A channel whose mask bit is set outputs its init bit in place of the waveform.
- R10: Polarity is applied after masking, so the output is (masked value) XOR (polarity bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| tick_fix | input | 1 | Tick strobe for source code 2 |
| tick_ext | input | 1 | Tick strobe for source code 3 |
| pwm_out | output | 8 | Channel outputs |

## Verification
The bench freezes the counter at arbitrary start values, including 0 and 0xFFFF, and compares all eight outputs against a model of compare, mask and polarity. A design that applied polarity before the mask, or that mishandled a compare of 0 or a compare above the modulus, would miss on these frozen points. It then runs the counter from each tick source and at a nonzero prescaler, and measures high and low run lengths. A wrong divide ratio or an off-by-one period would show up as a wrong run length. It also rewrites the modulus and compare value in the middle of a period. An unbuffered design would wrap early and shorten the first high and low runs.

A counter write followed by a read must show the reload, and the bench holds off `rsp_ready` to check that the response stays valid and stable. Writes to unmapped offsets must read back as zero and must leave both the outputs and the modulus untouched.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PS_W   = 3;
  localparam int CTL_LSB = 2;
  localparam int CTL_W  = 4;               // channel control bits [5:2]
  localparam int MODE_BIT  = 5;
  localparam int LEVEL_BIT = 3;
  localparam int CH_STRIDE = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MOD     = 8'h08;
  localparam int                OFS_CH_BASE = 'h0C;
  localparam logic [ADDR_W-1:0] OFS_START   = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_INIT    = 8'h5C;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_POL     = 8'h70;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } src_e;
endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
  import pwm8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [DATA_W-1:0]             rsp_rdata,
  input  logic [CW-1:0]                 cnt,
  output logic [PS_W-1:0]               ps,
  output src_e                          src,
  output logic [CW-1:0]                 mod_buf,
  output logic [CW-1:0]                 start_val,
  output logic [NCH-1:0]                init_bits,
  output logic [NCH-1:0]                mask_bits,
  output logic [NCH-1:0]                pol_bits,
  output logic [NCH-1:0][CTL_W-1:0]     ch_ctl,
  output logic [NCH-1:0][CW-1:0]        cv_buf,
  output logic                          cnt_wr
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CH_END = OFS_CH_BASE + CH_STRIDE * NCH;

  logic              accept, wr;
  logic              ch_hit, ch_is_cv;
  logic [ADDR_W-1:0] ch_off;
  logic [IW-1:0]     ch_sel;
  logic [DATA_W-1:0] rd_val;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign wr        = accept && req_write;

  assign ch_off   = req_addr - ADDR_W'(OFS_CH_BASE);
  assign ch_sel   = ch_off[IW+2:3];
  assign ch_is_cv = ch_off[2];
  assign ch_hit   = (int'(req_addr) >= OFS_CH_BASE) && (int'(req_addr) < CH_END) &&
                    (req_addr[1:0] == 2'b00);
  assign cnt_wr   = wr && (req_addr == OFS_COUNT);

  always_comb begin
    rd_val = '0;
    case (req_addr)
      OFS_CTRL:  begin
        rd_val[PS_W-1:0] = ps;
        rd_val[4:3]      = src;
      end
      OFS_COUNT: rd_val[CW-1:0]  = cnt;
      OFS_MOD:   rd_val[CW-1:0]  = mod_buf;
      OFS_START: rd_val[CW-1:0]  = start_val;
      OFS_INIT:  rd_val[NCH-1:0] = init_bits;
      OFS_MASK:  rd_val[NCH-1:0] = mask_bits;
      OFS_POL:   rd_val[NCH-1:0] = pol_bits;
      default: begin
        if (ch_hit) begin
          if (ch_is_cv) rd_val[CW-1:0] = cv_buf[ch_sel];
          else          rd_val[CTL_LSB+CTL_W-1:CTL_LSB] = ch_ctl[ch_sel];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps        <= '0;
      src       <= SRC_OFF;
      mod_buf   <= '0;
      start_val <= '0;
      init_bits <= '0;
      mask_bits <= '1;
      pol_bits  <= '0;
      ch_ctl    <= '0;
      cv_buf    <= '0;
    end else if (wr) begin
      case (req_addr)
        OFS_CTRL: begin
          ps  <= req_wdata[PS_W-1:0];
          src <= src_e'(req_wdata[4:3]);
        end
        OFS_MOD:   mod_buf   <= req_wdata[CW-1:0];
        OFS_START: start_val <= req_wdata[CW-1:0];
        OFS_INIT:  init_bits <= req_wdata[NCH-1:0];
        OFS_MASK:  mask_bits <= req_wdata[NCH-1:0];
        OFS_POL:   pol_bits  <= req_wdata[NCH-1:0];
        default: begin
          for (int n = 0; n < NCH; n++) begin
            if (ch_hit && (ch_sel == IW'(n))) begin
              if (ch_is_cv) cv_buf[n] <= req_wdata[CW-1:0];
              else          ch_ctl[n] <= req_wdata[CTL_LSB+CTL_W-1:CTL_LSB];
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter
  import pwm8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PS_W-1:0]        ps,
  input  src_e                   src,
  input  logic                   tick_fix,
  input  logic                   tick_ext,
  input  logic                   cnt_wr,
  input  logic [CW-1:0]          mod_buf,
  input  logic [CW-1:0]          start_val,
  input  logic [NCH-1:0][CW-1:0] cv_buf,
  output logic [CW-1:0]          cnt,
  output logic [CW-1:0]          mod_act,
  output logic [NCH-1:0][CW-1:0] cv_act,
  output logic                   advance,
  output logic                   reload
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic             src_tick, pre_last;
  logic [PRE_W-1:0] pre_cnt, pre_lim;

  always_comb begin
    case (src)
      SRC_SYS: src_tick = 1'b1;
      SRC_FIX: src_tick = tick_fix;
      SRC_EXT: src_tick = tick_ext;
      default: src_tick = 1'b0;
    endcase
  end

  assign pre_lim  = (PRE_W'(1) << ps) - PRE_W'(1);
  assign pre_last = (pre_cnt >= pre_lim);
  assign advance  = src_tick && pre_last;
  assign reload   = cnt_wr || (advance && (cnt >= mod_act));

  always_ff @(posedge clk) begin
    if (!rst_n)        pre_cnt <= '0;
    else if (cnt_wr)   pre_cnt <= '0;
    else if (src_tick) pre_cnt <= pre_last ? '0 : pre_cnt + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      mod_act <= '0;
      cv_act  <= '0;
    end else begin
      if (reload)       cnt <= start_val;
      else if (advance) cnt <= cnt + CW'(1);
      if (reload) begin
        mod_act <= mod_buf;
        cv_act  <= cv_buf;
      end
    end
  end
endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
  import pwm8_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0]    cnt,
  input  logic [CW-1:0]    cv,
  input  logic [CTL_W-1:0] ctl,
  input  logic             mask_b,
  input  logic             init_b,
  input  logic             pol_b,
  output logic             out
);
  logic edge_hi, raw, pre_pol;

  assign edge_hi = ctl[MODE_BIT-CTL_LSB] && ctl[LEVEL_BIT-CTL_LSB];
  assign raw     = edge_hi && (cnt < cv);
  assign pre_pol = mask_b ? init_b : raw;
  assign out     = pre_pol ^ pol_b;
endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic              tick_fix,
  input  logic              tick_ext,
  output logic [NCH-1:0]    pwm_out
);
  logic [PS_W-1:0]          ps;
  src_e                     src;
  logic [CW-1:0]            mod_buf, start_val, cnt, mod_act;
  logic [NCH-1:0]           init_bits, mask_bits, pol_bits;
  logic [NCH-1:0][CTL_W-1:0] ch_ctl;
  logic [NCH-1:0][CW-1:0]   cv_buf, cv_act;
  logic                     cnt_wr, advance, reload;

  pwm8_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cnt(cnt), .ps(ps), .src(src), .mod_buf(mod_buf), .start_val(start_val),
    .init_bits(init_bits), .mask_bits(mask_bits), .pol_bits(pol_bits),
    .ch_ctl(ch_ctl), .cv_buf(cv_buf), .cnt_wr(cnt_wr)
  );

  pwm8_counter #(.NCH(NCH), .CW(CW)) u_counter (
    .clk(clk), .rst_n(rst_n), .ps(ps), .src(src),
    .tick_fix(tick_fix), .tick_ext(tick_ext), .cnt_wr(cnt_wr),
    .mod_buf(mod_buf), .start_val(start_val), .cv_buf(cv_buf),
    .cnt(cnt), .mod_act(mod_act), .cv_act(cv_act),
    .advance(advance), .reload(reload)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm8_channel #(.CW(CW)) u_ch (
      .cnt(cnt), .cv(cv_act[g]), .ctl(ch_ctl[g]),
      .mask_b(mask_bits[g]), .init_b(init_bits[g]), .pol_b(pol_bits[g]),
      .out(pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm8_timer_chk.sv
module pwm8_timer_chk
  import pwm8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [31:0]    rsp_rdata,
  input src_e           src,
  input logic           cnt_wr,
  input logic           advance,
  input logic           reload,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  mod_act,
  input logic [CW-1:0]  start_val,
  input logic [NCH-1:0] mask_bits,
  input logic [NCH-1:0] init_bits,
  input logic [NCH-1:0] pol_bits,
  input logic [NCH-1:0] pwm_out
);
  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r3_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    ((src == SRC_OFF) && !cnt_wr) |=> $stable(cnt));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (cnt < mod_act) && !cnt_wr) |=> (cnt == CW'($past(cnt) + 1'b1)));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (cnt >= mod_act)) |=> (cnt == $past(start_val)));

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(start_val)));

  a_r8_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(mod_act));

  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out & mask_bits) == ((init_bits ^ pol_bits) & mask_bits)));
endmodule

bind pwm8_timer pwm8_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .src(src), .cnt_wr(cnt_wr),
  .advance(advance), .reload(reload), .cnt(cnt), .mod_act(mod_act),
  .start_val(start_val), .mask_bits(mask_bits), .init_bits(init_bits),
  .pol_bits(pol_bits), .pwm_out(pwm_out)
);

// File: tb/pwm8_timer_test.sv
`timescale 1ns/100ps
module pwm8_timer_test;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        tick_fix = 0, tick_ext = 0;
  logic [7:0]  pwm_out;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] b_cv [8];
  logic [5:0]  b_ctl [8];
  logic [7:0]  b_mask, b_init, b_pol;

  always #2.5 clk = ~clk;

  pwm8_timer uut (.*);

  initial begin : tick_gen
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      tick_fix = (k % 3) == 0;
      tick_ext = (k % 2) == 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] junk;
    bus(1'b1, a, d, junk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus(1'b0, a, 32'h0, d);
  endtask

  function automatic logic exp_pin(int n, logic [15:0] k);
    logic raw;
    raw = b_ctl[n][5] && b_ctl[n][3] && (k < b_cv[n]);
    return (b_mask[n] ? b_init[n] : raw) ^ b_pol[n];
  endfunction

  task automatic runlen(input int ch, output int n);
    logic lvl;
    lvl = pwm_out[ch];
    n = 0;
    while (pwm_out[ch] == lvl && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic setup_ch0(input logic [15:0] m, input logic [15:0] cv, input logic [31:0] ctrl);
    wr(8'h00, 0);
    wr(8'h60, 0); wr(8'h70, 0); wr(8'h5C, 0);
    wr(8'h0C, 32'h28); wr(8'h10, {16'h0, cv});
    wr(8'h08, {16'h0, m}); wr(8'h4C, 0);
    wr(8'h04, 0);
    wr(8'h00, ctrl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, d2;
    int h, l, bad;
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state
    check(pwm_out == 8'h00, "R1 reset outputs", pwm_out, 0);
    rd(8'h60, d); check(d == 32'hFF, "R1 reset mask", d, 32'hFF);
    rd(8'h00, d); check(d == 0, "R1 reset control", d, 0);
    rd(8'h08, d); check(d == 0, "R1 reset modulus", d, 0);

    // Frozen-counter random sweep
    wr(8'h00, 0);
    for (int it = 0; it < 30; it++) begin
      logic [15:0] k;
      for (int n = 0; n < 8; n++) begin
        int r = $urandom % 4;
        b_cv[n] = (r == 0) ? 16'h0 : (r == 1) ? 16'hFFFF : 16'($urandom);
        b_ctl[n] = 6'($urandom);
        if (($urandom % 4) != 0) b_ctl[n] = b_ctl[n] | 6'h28;
        wr(8'(12 + 8*n), {26'h0, b_ctl[n]});
        wr(8'(16 + 8*n), {16'h0, b_cv[n]});
      end
      b_mask = 8'($urandom); b_init = 8'($urandom); b_pol = 8'($urandom);
      k = (it % 7 == 0) ? 16'h0 : (it % 7 == 1) ? 16'hFFFF : 16'($urandom);
      wr(8'h60, {24'h0, b_mask}); wr(8'h5C, {24'h0, b_init}); wr(8'h70, {24'h0, b_pol});
      wr(8'h4C, {16'h0, k});
      wr(8'h08, 32'($urandom));
      wr(8'h04, 0);
      begin
        logic [7:0] e;
        for (int n = 0; n < 8; n++) e[n] = exp_pin(n, k);
        check(pwm_out == e, "R6/R7/R9/R10 frozen compare", pwm_out, e);
      end
      if (it % 5 == 0) begin
        rd(8'h2C, d); check(d == {26'h0, b_ctl[4] & 6'h3C}, "R1 channel control readback", d, {26'h0, b_ctl[4] & 6'h3C});
        rd(8'h48, d); check(d == {16'h0, b_cv[7]}, "R1 compare readback", d, {16'h0, b_cv[7]});
      end
    end

    // Directed mask plus polarity
    wr(8'h60, 32'hFF); wr(8'h5C, 32'hA5); wr(8'h70, 32'h0F);
    @(negedge clk);
    check(pwm_out == 8'hAA, "R9/R10 mask then polarity", pwm_out, 8'hAA);

    // Counter live read and reload on write
    rd(8'h04, d); @(negedge clk); rd(8'h04, d2);
    check(d == d2, "R3 stopped counter holds", d2, d);
    wr(8'h4C, 32'h1234); wr(8'h04, 0); rd(8'h04, d);
    check(d == 32'h1234, "R5 counter write reloads start", d, 32'h1234);
    wr(8'h08, 32'hFFFF); wr(8'h4C, 32'h0100); wr(8'h04, 0);
    wr(8'h00, 32'h08);
    rd(8'h04, d); rd(8'h04, d2);
    check(d2 - d == 2, "R5 live count advances", d2 - d, 2);
    wr(8'h04, 0); rd(8'h04, d);
    check(d == 32'h0101, "R5 reload while running", d, 32'h0101);

    // Period shape, system clock
    setup_ch0(16'd4, 16'd2, 32'h08);
    runlen(0, h); runlen(0, l); runlen(0, h); runlen(0, l);
    check(h == 2, "R4/R6 high run", h, 2);
    check(l == 3, "R4 low run", l, 3);

    // Prescaler 2^2
    setup_ch0(16'd4, 16'd2, 32'h0A);
    runlen(0, h); runlen(0, l); runlen(0, h); runlen(0, l);
    check(h == 8, "R3 prescaled high", h, 8);
    check(l == 12, "R3 prescaled low", l, 12);

    // Fixed tick every 3rd cycle
    setup_ch0(16'd4, 16'd2, 32'h10);
    runlen(0, h); runlen(0, l); runlen(0, h); runlen(0, l);
    check(h == 6, "R3 fixed source high", h, 6);
    check(l == 9, "R3 fixed source low", l, 9);

    // External tick every 2nd cycle
    setup_ch0(16'd4, 16'd2, 32'h18);
    runlen(0, h); runlen(0, l); runlen(0, h); runlen(0, l);
    check(h == 4, "R3 external source high", h, 4);
    check(l == 6, "R3 external source low", l, 6);

    // Compare extremes
    setup_ch0(16'd4, 16'd0, 32'h08);
    bad = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (pwm_out[0] !== 1'b0) bad++; end
    check(bad == 0, "R7 compare zero constant low", bad, 0);
    setup_ch0(16'd4, 16'd5, 32'h08);
    bad = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (pwm_out[0] !== 1'b1) bad++; end
    check(bad == 0, "R7 compare above modulus constant high", bad, 0);

    // Buffered modulus and compare
    wr(8'h00, 0);
    wr(8'h10, 32'd5); wr(8'h08, 32'd9); wr(8'h4C, 0); wr(8'h04, 0);
    wr(8'h10, 32'd1); wr(8'h08, 32'd3);
    wr(8'h00, 32'h08);
    runlen(0, h);
    check(h == 5, "R8 old compare kept in period", h, 5);
    runlen(0, l);
    check(l == 5, "R8 old modulus kept in period", l, 5);
    runlen(0, h); runlen(0, l);
    check(h == 1 && l == 3, "R8 new values after reload", {h[15:0], l[15:0]}, {16'd1, 16'd3});

    // Back-pressure on the response
    wr(8'h00, 0);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 8'h08;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
    bad = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (!rsp_valid || req_ready || rsp_rdata != d) bad++;
    end
    check(bad == 0 && d == 32'd3, "R2 response held under back-pressure", d, 3);
    rsp_ready = 1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R2 response released", rsp_valid, 0);

    // Unmapped offsets
    d2 = {24'h0, pwm_out};
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h74, 32'h1234); wr(8'h09, 32'h7);
    rd(8'h50, d); check(d == 0, "R1 unmapped read zero", d, 0);
    rd(8'h08, d); check(d == 32'd3, "R1 unmapped write ignored", d, 3);
    check({24'h0, pwm_out} == d2, "R1 unmapped write leaves outputs", pwm_out, d2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule